// File: doc/BRIEF.md
# SMBus Register-Pointer Target

This block is the bus-facing front end of a small register file. It oversamples the two SMBus wires with a fast system clock and finds start and stop conditions. It answers one fixed 7-bit address. Incoming bytes are shifted in MSB first, and the block drives the acknowledge bit. Outgoing read bytes are shifted out on SDA by pulling the line low for each zero bit. The register file itself lives outside the block, behind a plain address, write-data, write-enable and read-data port.

Every write transaction uses its first data byte as the new register pointer. An optional second byte is stored at that pointer. A read transaction returns the byte at the current pointer, and the pointer keeps its value from one transaction to the next. Packet error checking with CRC-8 is optional. It is active only when the master clocks an extra byte. One pointer value makes no store: it produces a trigger pulse instead. Writes to one configuration address are also snooped to enable the two bus-stuck timeouts.

Top module: `smbus_ptr_target`

## Requirements
- R1: After reset, and after any stop condition (SDA rising while SCL is high), SDA is released (`sda_low_o`=0), `reg_we_o` and `oneshot_o` are 0, and the pointer is 0x00 after reset.
- R2: A start is SDA falling while SCL is high. Bits are sampled on SCL rising edges, MSB first. The ninth SCL pulse of each byte is the acknowledge slot, and the target acknowledges by holding `sda_low_o`=1 from the SCL fall after bit 8 until the SCL fall after pulse 9.
- R3: The first byte after a start holds the device address in bits 7:1 (0x4C by default) and R/W in bit 0 (0 = write, 1 = read). On a mismatch the target does not acknowledge, ignores the bus until the next start, and writes nothing.
- R4: In a write, the first data byte is acknowledged and loaded into the pointer. A second data byte is acknowledged and produces exactly one `reg_we_o` pulse, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte.
- R5: In a read, the target shifts out the byte on `reg_rdata_i` for the current pointer, MSB first. No pointer write is needed first, and a pointer set in an earlier transaction stays in effect.
- R6: A data byte written while the pointer is 0x0F gives a single-cycle `oneshot_o` pulse whatever its value, and no `reg_we_o`.
- R7: Write PEC: a third data byte is compared with the CRC-8 (polynomial x^8+x^2+x+1, i.e. 0x07, start value 0x00, MSB first) of all earlier bytes of the transaction, address bytes included. The target acknowledges on a match and does not acknowledge on a mismatch. The second byte has already been stored either way.
- R8: Read PEC: if the master acknowledges the data byte, the target sends the CRC-8 of all bytes so far. A repeated start keeps the pointer and lets the CRC run on across both parts.
- R9: A data byte written to pointer 0x22 also sets the timeout enables: bit 7 enables the SCL-low timeout and bit 6 the SDA-low timeout. Both are off after reset. When an enabled line stays low for `TMO_CYCLES` clocks during a transaction, the target returns to idle and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line as seen on the pad |
| sda_i | input | 1 | SMBus data line as seen on the pad |
| sda_low_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_addr_o | output | 8 | Register pointer, used as read and write address |
| reg_wdata_o | output | 8 | Write data for the register file |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |
| oneshot_o | output | 1 | One-cycle trigger for a write to pointer 0x0F |

## Verification
The pointer mechanism is tried with four kinds of transaction: pointer-plus-data writes, pointer-only writes followed by two separate reads, a read straight after reset, and a write joined to a read by a repeated start. Together these show whether the pointer is loaded from the right byte and whether it persists. A foreign address followed by an extra byte shows that the target stays silent. Write PEC is tried with both a correct and a corrupted check byte, and read PEC both with and without the repeated start, which shows whether the CRC covers every byte. A stall in the acknowledge slot is run with the timeouts off, with only the SCL enable set, and with only the SDA enable set, which shows that each enable bit works on its own.

// File: rtl/smbus_ptr_target.sv
module smbus_ptr_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter logic [7:0] ONESHOT_PTR = 8'h0F,
  parameter logic [7:0] TMO_PTR     = 8'h22,
  parameter int         TMO_CYCLES  = 2500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_low_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  input  logic [7:0] reg_rdata_i,
  output logic       oneshot_o
);
  localparam int TW = $clog2(TMO_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_RD, S_WAIT} st_t;

  st_t        state;
  logic [2:0] scl_sh, sda_sh;
  logic [3:0] cnt;
  logic [1:0] idx, tmo_en;
  logic [7:0] rx, tx, ptr, crc;
  logic       sda_low;
  logic [TW-1:0] scl_tc, sda_tc;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return r;
  endfunction

  wire scl_rise  = scl_sh[1] & ~scl_sh[2];
  wire scl_fall  = ~scl_sh[1] & scl_sh[2];
  wire start_det = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
  wire stop_det  = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];
  wire tmo_fire  = (state != S_IDLE) &&
                   ((tmo_en[1] && scl_tc == TW'(TMO_CYCLES)) ||
                    (tmo_en[0] && sda_tc == TW'(TMO_CYCLES)));

  assign sda_low_o  = sda_low;
  assign reg_addr_o = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
      scl_tc <= '0;
      sda_tc <= '0;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
      if (state == S_IDLE || scl_sh[1]) scl_tc <= '0;
      else if (scl_tc != TW'(TMO_CYCLES)) scl_tc <= scl_tc + 1'b1;
      if (state == S_IDLE || sda_sh[1]) sda_tc <= '0;
      else if (sda_tc != TW'(TMO_CYCLES)) sda_tc <= sda_tc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; idx <= '0; tmo_en <= '0;
      rx <= '0; tx <= 8'hFF; ptr <= '0; crc <= '0; sda_low <= 1'b0;
      reg_we_o <= 1'b0; reg_wdata_o <= '0; oneshot_o <= 1'b0;
    end else begin
      reg_we_o  <= 1'b0;
      oneshot_o <= 1'b0;
      if (tmo_fire) begin
        state <= S_IDLE; sda_low <= 1'b0;
      end else if (start_det) begin
        if (state == S_IDLE) crc <= '0;
        state <= S_ADDR; cnt <= '0; sda_low <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE; sda_low <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            rx <= {rx[6:0], sda_sh[1]};
            cnt <= cnt + 1'b1;
          end else if (cnt == 4'd8) begin
            cnt <= 4'd9;
            if (state == S_RD && sda_sh[1]) state <= S_WAIT;
          end
        end else if (scl_fall) begin
          if (cnt >= 4'd1 && cnt <= 4'd7) begin
            if (state == S_RD) begin
              sda_low <= ~tx[6];
              tx <= {tx[6:0], 1'b1};
            end
          end else if (cnt == 4'd8) begin
            sda_low <= 1'b0;
            case (state)
              S_ADDR: begin
                if (rx[7:1] == DEV_ADDR) begin
                  sda_low <= 1'b1; crc <= crc8(crc, rx); idx <= '0;
                  state <= rx[0] ? S_RD : S_WR;
                end else state <= S_IDLE;
              end
              S_WR: begin
                case (idx)
                  2'd0: begin ptr <= rx; sda_low <= 1'b1; crc <= crc8(crc, rx); end
                  2'd1: begin
                    if (ptr == ONESHOT_PTR) oneshot_o <= 1'b1;
                    else begin reg_we_o <= 1'b1; reg_wdata_o <= rx; end
                    if (ptr == TMO_PTR) tmo_en <= rx[7:6];
                    sda_low <= 1'b1; crc <= crc8(crc, rx);
                  end
                  2'd2: sda_low <= (rx == crc);
                  default: sda_low <= 1'b0;
                endcase
                if (idx != 2'd3) idx <= idx + 1'b1;
              end
              default: ;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            sda_low <= 1'b0;
            if (state == S_RD) begin
              case (idx)
                2'd0: begin
                  tx <= reg_rdata_i; sda_low <= ~reg_rdata_i[7];
                  crc <= crc8(crc, reg_rdata_i); idx <= 2'd1;
                end
                2'd1: begin tx <= crc; sda_low <= ~crc[7]; idx <= 2'd2; end
                default: tx <= 8'hFF;
              endcase
            end
          end
        end
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> !sda_low_o); // R3
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (state == S_IDLE && !sda_low_o)); // R1
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !tmo_fire) |=> (state == S_ADDR && cnt == 4'd0)); // R2
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o); // R4
  AST_WE_OR_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && oneshot_o)); // R6
  AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (state == S_IDLE && !sda_low_o)); // R9
endmodule

// File: tb/smbus_ptr_target_bench.sv
module smbus_ptr_target_bench;
  localparam int TMO = 3000;
  localparam int Q   = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_low, reg_we, oneshot;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [16:0] exp_q [$];
  int errs = 0, checks = 0;
  wire sda_line = sda_m & ~sda_low;

  always #5 clk = ~clk;

  smbus_ptr_target #(.TMO_CYCLES(TMO)) u_smbus_ptr_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_low_o(sda_low),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
    .reg_rdata_i(reg_rdata), .oneshot_o(oneshot));

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes/triggers as they appear
  always @(negedge clk) begin
    if (rst_n && (reg_we || oneshot)) begin
      if (exp_q.size() == 0) chk(0, "R3/R4/R6 unexpected strobe", {oneshot, reg_addr, reg_wdata}, 0);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        if (e[16]) chk(oneshot && !reg_we && reg_addr == e[15:8], "R6 trigger", {oneshot, reg_addr}, {1'b1, e[15:8]});
        else chk(reg_we && !oneshot && {reg_addr, reg_wdata} == e[15:0], "R4 write", {reg_addr, reg_wdata}, e[15:0]);
      end
    end
  end

  function automatic logic [7:0] crc_bits(input logic [7:0] c, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(); scl = 1'b1; wq(2); sda_m = 1'b0; wq(2); scl = 1'b0; wq();
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(); scl = 1'b1; wq(2); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
    end
  endtask

  task automatic ack_slot(output bit ack);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    send_bits(b); ack_slot(ack);
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq();
    end
    sda_m = ~mack; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic reg_write(input logic [7:0] p, input logic [7:0] d, input string req);
    bit a0, a1, a2;
    exp_q.push_back({1'b0, p, d});
    bus_start; wr_byte(8'h98, a0); wr_byte(p, a1); wr_byte(d, a2); bus_stop;
    chk(a0 && a1 && a2, req, {a0, a1, a2}, 3'b111);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bit a0, a1;
    bus_start; wr_byte(8'h98, a0); wr_byte(p, a1); bus_stop;
    chk(a0 && a1, "R4 pointer-only ack", {a0, a1}, 2'b11);
  endtask

  task automatic reg_read(output logic [7:0] d);
    bit a0;
    bus_start; wr_byte(8'h99, a0); rd_byte(1'b0, d); bus_stop;
    chk(a0, "R3 read address ack", a0, 1);
  endtask

  task automatic stall_test(input logic [7:0] cfg, input bit expect_release, input string req);
    bit a;
    logic [7:0] d;
    reg_write(8'h22, cfg, "R9 config write");
    bus_start; send_bits(8'h98);
    wq(); chk(sda_low == 1'b1, "R2 ack driven", sda_low, 1);
    repeat (TMO + 500) @(negedge clk);
    chk(sda_low == !expect_release, req, sda_low, !expect_release);
    ack_slot(a);
    chk(a == !expect_release, req, a, !expect_release);
    bus_stop;
    d = 8'h00;
  endtask

  initial begin
    logic [7:0] d, d2, pec, c;
    bit a0, a1, a2, a3;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sda_low && !reg_we && !oneshot, "R1 reset state", {sda_low, reg_we, oneshot}, 0);
    chk(reg_addr == 8'h00, "R1 pointer reset", reg_addr, 0);

    reg_read(d);
    chk(d == 8'hA5, "R5 read at reset pointer", d, 8'hA5);

    reg_write(8'h31, 8'h5A, "R4 write acks");
    chk(!sda_low, "R1 released after stop", sda_low, 0);
    reg_read(d);
    chk(d == 8'h5A, "R5 read back written byte", d, 8'h5A);

    bus_start; wr_byte(8'h96, a0); wr_byte(8'h31, a1); bus_stop;
    chk(!a0 && !a1, "R3 foreign address ignored", {a0, a1}, 0);
    set_ptr(8'h31); reg_read(d);
    chk(d == 8'h5A, "R3 no store from foreign address", d, 8'h5A);

    set_ptr(8'h10); reg_read(d); reg_read(d2);
    chk(d == 8'hB5 && d2 == 8'hB5, "R5 pointer persists", {d, d2}, 16'hB5B5);

    exp_q.push_back({1'b1, 8'h0F, 8'h00});
    bus_start; wr_byte(8'h98, a0); wr_byte(8'h0F, a1); wr_byte(8'hAB, a2); bus_stop;
    chk(a0 && a1 && a2, "R6 trigger acks", {a0, a1, a2}, 3'b111);
    chk(mem[8'h0F] == (8'h0F ^ 8'hA5), "R6 no store", mem[8'h0F], 8'h0F ^ 8'hA5);

    c = crc_bits(crc_bits(crc_bits(8'h00, 8'h98), 8'h40), 8'h3C);
    exp_q.push_back({1'b0, 8'h40, 8'h3C});
    bus_start; wr_byte(8'h98, a0); wr_byte(8'h40, a1); wr_byte(8'h3C, a2); wr_byte(c, a3); bus_stop;
    chk(a0 && a1 && a2 && a3, "R7 good PEC acked", {a0, a1, a2, a3}, 4'hF);

    c = crc_bits(crc_bits(crc_bits(8'h00, 8'h98), 8'h41), 8'h11) ^ 8'hFF;
    exp_q.push_back({1'b0, 8'h41, 8'h11});
    bus_start; wr_byte(8'h98, a0); wr_byte(8'h41, a1); wr_byte(8'h11, a2); wr_byte(c, a3); bus_stop;
    chk(a2 && !a3, "R7 bad PEC not acked", {a2, a3}, 2'b10);

    set_ptr(8'h40);
    bus_start; wr_byte(8'h99, a0); rd_byte(1'b1, d); rd_byte(1'b0, pec); bus_stop;
    c = crc_bits(crc_bits(8'h00, 8'h99), 8'h3C);
    chk(d == 8'h3C, "R8 data before PEC", d, 8'h3C);
    chk(pec == c, "R8 read PEC", pec, c);

    bus_start; wr_byte(8'h98, a0); wr_byte(8'h31, a1);
    bus_start; wr_byte(8'h99, a2); rd_byte(1'b1, d); rd_byte(1'b0, pec); bus_stop;
    c = crc_bits(crc_bits(crc_bits(crc_bits(8'h00, 8'h98), 8'h31), 8'h99), 8'h5A);
    chk(a0 && a1 && a2 && d == 8'h5A, "R8 repeated start read", d, 8'h5A);
    chk(pec == c, "R8 PEC across repeated start", pec, c);

    stall_test(8'h00, 1'b0, "R9 timeouts off after reset hold");
    stall_test(8'h80, 1'b1, "R9 SCL timeout releases");
    stall_test(8'h40, 1'b1, "R9 SDA timeout releases");
    reg_write(8'h22, 8'h00, "R9 config clear");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected strobes seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule